// File: doc/BRIEF.md
# Buffered 8-bit PWM Channel

This block produces one pulse-width modulated output from an 8-bit counter that can count up or down. The counter moves only on cycles where an external clock-enable tick is high, so a prescaler outside the block sets the counting rate. The count is compared with an active period and an active duty value. Software-side writes arrive as simple strobes. Period and duty writes land in buffer registers, and a counter-write strobe restarts the waveform.

The active period and duty are taken from the buffers only at safe points. These points are the end of the effective period, a counter write, or any cycle while the channel is disabled. This keeps every cycle either wholly old or wholly new. In left-aligned mode the counter ramps up and wraps. In center-aligned mode it rises to the period and falls back to zero. Disabling the channel freezes the count, so the waveform picks up where it stopped.

Top module: `pwm8_chan`

## Requirements
- R1: After reset the count reads 0 and the output is low.
- R2: Left-aligned mode (center=0), active period P≥1: on each tick the count goes 0,1,…,P−1 and then back to 0. Each return to 0 loads the buffers. The output equals pol while count < duty and equals the inverse of pol otherwise, so pol=1 makes duty the high time.
- R3: Center-aligned mode (center=1), P≥1: the count rises from 0 up to P and then falls back to 0, giving a cycle of 2·P ticks. The buffers load when the count reaches 0. The output rule is the same as in R2.
- R4: If duty ≥ period, or if the period is 0, the output stays at pol. An enabled channel with period 0 keeps its count at 0.
- R5: While enabled, period and duty writes go only to the buffers. The running cycle finishes with the old values.
- R6: While disabled, period and duty writes become active at once. Disabling the channel also moves any pending buffer values into the active registers.
- R7: A counter-write strobe sets the count to 0 and the direction to up. It loads the active values from the buffers and sets the output to pol on the next edge.
- R8: With en low the count and output hold, ticks included. When en returns high, counting continues from the held count.
- R9: While disabled, a tick with an active period of 0 clears the count.
- R10: Without a tick or counter write, the count and the output do not change.
- R11: The count port always shows the current count, and observing it has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable from the external prescaler |
| en | input | 1 | Channel enable |
| pol | input | 1 | Start level of each cycle |
| center | input | 1 | 1 selects center-aligned counting |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | 8 | Period write data |
| duty_wr | input | 1 | Duty write strobe |
| duty_wdata | input | 8 | Duty write data |
| cnt_wr | input | 1 | Counter write strobe (restart) |
| cnt_rdata | output | 8 | Current count |
| pwm_out | output | 1 | Waveform output |

## Verification
The count and the output are both registered. A tick or counter-write strobe seen at one rising edge is therefore visible right after that edge, one cycle after the stimulus was applied. Period and duty writes while disabled show up as a changed wrap point only at the next tick. The bench drives each strobe for exactly one clock from a falling edge and samples at the following falling edge. As a result, each check sees exactly one advanced step. The sweep compares every step against counts and levels worked out arithmetically from the tick index.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
    localparam int CNT_W = 8;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t per_buf;
        cnt_t duty_buf;
        cnt_t per_act;
        cnt_t duty_act;
    } regs_t;

    typedef struct packed {
        cnt_t cnt;
        logic down;
    } ctr_t;
endpackage

// File: rtl/pwm8_regs.sv
module pwm8_regs
    import pwm8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic per_wr,
    input  cnt_t per_wdata,
    input  logic duty_wr,
    input  cnt_t duty_wdata,
    input  logic load,
    output cnt_t per_act_q,
    output cnt_t duty_act_q,
    output cnt_t per_act_d,
    output cnt_t duty_act_d
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (per_wr)  r_d.per_buf  = per_wdata;
        if (duty_wr) r_d.duty_buf = duty_wdata;
        // disabled: pass straight through; enabled: only at safe points
        if (!en || load) begin
            r_d.per_act  = r_d.per_buf;
            r_d.duty_act = r_d.duty_buf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign per_act_q  = r_q.per_act;
    assign duty_act_q = r_q.duty_act;
    assign per_act_d  = r_d.per_act;
    assign duty_act_d = r_d.duty_act;
endmodule

// File: rtl/pwm8_counter.sv
module pwm8_counter
    import pwm8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic center,
    input  logic cnt_wr,
    input  cnt_t per_act,
    output cnt_t cnt_q,
    output cnt_t cnt_d,
    output logic period_end
);
    localparam cnt_t ONE = cnt_t'(1);

    ctr_t c_d, c_q;

    always_comb begin
        c_d        = c_q;
        period_end = 1'b0;
        if (cnt_wr) begin
            c_d.cnt  = '0;
            c_d.down = 1'b0;
        end else if (tick && en) begin
            if (per_act == '0) begin
                c_d.cnt    = '0;
                c_d.down   = 1'b0;
                period_end = 1'b1;
            end else if (!center) begin
                c_d.down = 1'b0;
                if (c_q.cnt >= per_act - ONE) begin
                    c_d.cnt    = '0;
                    period_end = 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt + ONE;
                end
            end else if (!c_q.down) begin
                if (c_q.cnt >= per_act) begin
                    if (c_q.cnt <= ONE) begin
                        c_d.cnt    = '0;
                        period_end = 1'b1;
                    end else begin
                        c_d.cnt  = c_q.cnt - ONE;
                        c_d.down = 1'b1;
                    end
                end else begin
                    c_d.cnt = c_q.cnt + ONE;
                end
            end else begin
                if (c_q.cnt <= ONE) begin
                    c_d.cnt    = '0;
                    c_d.down   = 1'b0;
                    period_end = 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt - ONE;
                end
            end
        end else if (tick && per_act == '0) begin
            // disabled with zero period: clear on the tick
            c_d.cnt  = '0;
            c_d.down = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_q = c_q.cnt;
    assign cnt_d = c_d.cnt;
endmodule

// File: rtl/pwm8_wave.sv
module pwm8_wave
    import pwm8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic force_start,
    input  logic pol,
    input  cnt_t cnt_nx,
    input  cnt_t per_nx,
    input  cnt_t duty_nx,
    output logic out_q
);
    logic out_d;
    logic at_start;

    always_comb begin
        at_start = (per_nx == '0) || (duty_nx >= per_nx) || (cnt_nx < duty_nx);
        out_d    = out_q;
        if (force_start)  out_d = pol;
        else if (upd)     out_d = at_start ? pol : ~pol;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end
endmodule

// File: rtl/pwm8_chan.sv
module pwm8_chan
    import pwm8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       pol,
    input  logic       center,
    input  logic       per_wr,
    input  logic [7:0] per_wdata,
    input  logic       duty_wr,
    input  logic [7:0] duty_wdata,
    input  logic       cnt_wr,
    output logic [7:0] cnt_rdata,
    output logic       pwm_out
);
    cnt_t per_act, duty_act, per_nx, duty_nx;
    cnt_t cnt_q, cnt_nx;
    logic period_end;
    logic load;

    assign load = cnt_wr | period_end;

    pwm8_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .per_wr     (per_wr),
        .per_wdata  (per_wdata),
        .duty_wr    (duty_wr),
        .duty_wdata (duty_wdata),
        .load       (load),
        .per_act_q  (per_act),
        .duty_act_q (duty_act),
        .per_act_d  (per_nx),
        .duty_act_d (duty_nx)
    );

    pwm8_counter u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .tick       (tick),
        .center     (center),
        .cnt_wr     (cnt_wr),
        .per_act    (per_act),
        .cnt_q      (cnt_q),
        .cnt_d      (cnt_nx),
        .period_end (period_end)
    );

    pwm8_wave u_wave (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd         (en & tick),
        .force_start (cnt_wr),
        .pol         (pol),
        .cnt_nx      (cnt_nx),
        .per_nx      (per_nx),
        .duty_nx     (duty_nx),
        .out_q       (pwm_out)
    );

    assign cnt_rdata = cnt_q;

    logic unused_duty;
    assign unused_duty = ^duty_act;
endmodule

// File: rtl/pwm8_chan_chk.sv
module pwm8_chan_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       en,
    input logic       pol,
    input logic       center,
    input logic       cnt_wr,
    input logic [7:0] cnt_rdata,
    input logic       pwm_out,
    input logic [7:0] act_per
);
    a_r7_cnt_write_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_rdata == 8'd0) && (pwm_out == $past(pol)));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt_rdata) && $stable(pwm_out));

    a_r8_disabled_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr && act_per != 8'd0) |=> $stable(cnt_rdata) && $stable(pwm_out));

    a_r9_zero_period_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && tick && !cnt_wr && act_per == 8'd0) |=> cnt_rdata == 8'd0);

    a_r2_left_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !center && !cnt_wr && act_per != 8'd0 &&
         cnt_rdata >= act_per - 8'd1) |=> cnt_rdata == 8'd0);

    a_r3_center_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && center && !cnt_wr && act_per > 8'd1 && cnt_rdata == act_per)
        |=> cnt_rdata == $past(act_per) - 8'd1);
endmodule

bind pwm8_chan pwm8_chan_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .en        (en),
    .pol       (pol),
    .center    (center),
    .cnt_wr    (cnt_wr),
    .cnt_rdata (cnt_rdata),
    .pwm_out   (pwm_out),
    .act_per   (per_act)
);

// File: tb/pwm8_chan_test.sv
`timescale 1ns/1ps
module pwm8_chan_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, en = 1'b0, pol = 1'b0, center = 1'b0;
    logic       per_wr = 1'b0, duty_wr = 1'b0, cnt_wr = 1'b0;
    logic [7:0] per_wdata = '0, duty_wdata = '0;
    logic [7:0] cnt_rdata;
    logic       pwm_out;
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm8_chan uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .pol(pol), .center(center),
        .per_wr(per_wr), .per_wdata(per_wdata), .duty_wr(duty_wr), .duty_wdata(duty_wdata),
        .cnt_wr(cnt_wr), .cnt_rdata(cnt_rdata), .pwm_out(pwm_out)
    );

    task automatic chk_cnt(string tag, logic [7:0] exp);
        total++;
        if (cnt_rdata !== exp) begin
            bad++;
            $display("FAIL %s count: actual=%0d expected=%0d", tag, cnt_rdata, exp);
        end
    endtask

    task automatic chk_out(string tag, logic exp);
        total++;
        if (pwm_out !== exp) begin
            bad++;
            $display("FAIL %s output: actual=%0b expected=%0b", tag, pwm_out, exp);
        end
    endtask

    task automatic step();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic wr_per(logic [7:0] v);
        @(negedge clk) begin per_wr = 1'b1; per_wdata = v; end
        @(negedge clk) per_wr = 1'b0;
    endtask

    task automatic wr_duty(logic [7:0] v);
        @(negedge clk) begin duty_wr = 1'b1; duty_wdata = v; end
        @(negedge clk) duty_wr = 1'b0;
    endtask

    task automatic wr_cnt();
        @(negedge clk) cnt_wr = 1'b1;
        @(negedge clk) cnt_wr = 1'b0;
    endtask

    task automatic set_en(logic v);
        @(negedge clk) en = v;
    endtask

    function automatic logic [7:0] exp_cnt(int p, bit c, int k);
        int pos;
        if (p == 0) return 8'd0;
        if (!c) return 8'(k % p);
        pos = k % (2 * p);
        return (pos <= p) ? 8'(pos) : 8'(2 * p - pos);
    endfunction

    task automatic setup(int p, int d, bit pl, bit c);
        set_en(1'b0);
        @(negedge clk) begin pol = pl; center = c; end
        wr_per(8'(p));
        wr_duty(8'(d));
        wr_cnt();
        set_en(1'b1);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_cnt("R1", 8'd0);
        chk_out("R1", 1'b0);
        rst_n = 1'b1;

        // sweep: period, duty, polarity, alignment
        for (int c = 0; c < 2; c++)
            for (int pl = 0; pl < 2; pl++)
                for (int p = 0; p < 7; p++)
                    for (int d = 0; d < 8; d++) begin
                        int n;
                        string tag;
                        tag = (p == 0 || d >= p) ? "R4" : (c != 0 ? "R3" : "R2");
                        setup(p, d, pl[0], c[0]);
                        chk_cnt("R7", 8'd0);
                        chk_out("R7", pl[0]);
                        n = (c != 0) ? 4 * p + 1 : 2 * p + 2;
                        for (int k = 1; k <= n; k++) begin
                            logic [7:0] ec;
                            logic eo;
                            step();
                            ec = exp_cnt(p, c[0], k);
                            eo = (p == 0 || d >= p || int'(ec) < d) ? pl[0] : ~pl[0];
                            chk_cnt(tag, ec);
                            chk_out(tag, eo);
                        end
                    end

        // R5 left: buffered writes wait for the wrap
        setup(4, 2, 1'b1, 1'b0);
        step(); step();
        wr_per(8'd6); wr_duty(8'd5);
        step();
        chk_cnt("R5", 8'd3); chk_out("R5", 1'b0);
        step();
        chk_cnt("R5", 8'd0); chk_out("R5", 1'b1);
        repeat (5) step();
        chk_cnt("R5", 8'd5); chk_out("R5", 1'b0);
        step();
        chk_cnt("R5", 8'd0);

        // R5 center: new period only after return to zero
        setup(3, 1, 1'b0, 1'b1);
        step();
        wr_per(8'd2);
        step(); step();
        chk_cnt("R5", 8'd3);
        repeat (3) step();
        chk_cnt("R5", 8'd0);
        step(); step(); step();
        chk_cnt("R5", 8'd1);

        // R6: disabled writes are immediate
        setup(6, 3, 1'b1, 1'b0);
        repeat (4) step();
        set_en(1'b0);
        wr_per(8'd5);
        set_en(1'b1);
        step();
        chk_cnt("R6", 8'd0);
        step();
        wr_per(8'd3);
        set_en(1'b0);
        set_en(1'b1);
        step();
        chk_cnt("R6", 8'd2);
        step();
        chk_cnt("R6", 8'd0);

        // R8: freeze while disabled, resume after
        setup(5, 2, 1'b1, 1'b0);
        repeat (3) step();
        set_en(1'b0);
        repeat (3) step();
        chk_cnt("R8", 8'd3); chk_out("R8", 1'b0);
        set_en(1'b1);
        step();
        chk_cnt("R8", 8'd4);

        // R9: zero period while disabled clears on next tick
        set_en(1'b0);
        wr_per(8'd0);
        chk_cnt("R9", 8'd4);
        step();
        chk_cnt("R9", 8'd0);

        // R10 / R11: no tick, no movement; reading is passive
        setup(5, 2, 1'b0, 1'b0);
        step(); step();
        repeat (5) @(negedge clk);
        chk_cnt("R10", 8'd2); chk_out("R10", 1'b1);
        chk_cnt("R11", 8'd2);
        step();
        chk_cnt("R11", 8'd3);

        // R7: counter write while running loads buffers at once
        setup(5, 2, 1'b0, 1'b0);
        step(); step();
        chk_out("R2", 1'b1);
        wr_per(8'd3);
        wr_cnt();
        chk_cnt("R7", 8'd0); chk_out("R7", 1'b0);
        step(); step(); step();
        chk_cnt("R7", 8'd0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule